// File: doc/BRIEF.md
# Bidirectional Half-Ring Mesh Stop

This block is one stop of a two-dimensional on-chip network in which every row and every column is a half ring that carries traffic in both directions. The stop sits at a fixed (row, column) position given by parameters. It has four ring links, each a slotted input and a slotted output that move at most one packet per cycle: travelling toward higher rows, toward lower rows, toward higher columns and toward lower columns. It also has a local inject port and a local eject port. Every ring hop through the stop takes exactly one clock cycle.

Routing is dimension ordered. A packet first rides its column ring until its destination row is reached, then turns onto the row ring toward its destination column, and leaves the network at the stop whose coordinates match. A ring does not wrap around the die. A packet that would run off an edge is sent back along the same ring in the opposite direction. Traffic already on a ring always keeps its slot. A turning packet and a locally injected packet only take a slot that the ring leaves empty. A packet that cannot turn, or cannot leave because the eject port is stalled, keeps circulating.

Local packets enter through a small FIFO with a valid/ready handshake. `inj_ready` is high whenever the FIFO has a free entry, and a packet is taken on every clock edge where `inj_valid` and `inj_ready` are both high. The eject port is a registered valid/ready source. Once `ej_valid` is raised, the packet stays on `ej_pkt` unchanged until a clock edge where `ej_ready` is high. Ring links have no back-pressure.

Top module: `mesh_ring_stop`

## Requirements
- R1: After reset, all four ring outputs and `ej_valid` are low and `inj_ready` is high.
- R2: Packet layout and direction index. A packet is {destination row in the top ROW_W bits, destination column in the next COL_W bits, payload in the low PAY_W bits}. Link index 0 travels toward higher rows, 1 toward lower rows, 2 toward higher columns and 3 toward lower columns. A packet arriving on link d that is not ejected and does not turn leaves on output d one cycle later, unchanged.
- R3: When the stop is the last one in direction d (the highest row for 0, row 0 for 1, the highest column for 2, column 0 for 3), a packet that would continue in direction d leaves instead on the opposite output of the same ring (d XOR 1) one cycle later.
- R4: A packet on a column link (0 or 1) whose row matches and whose column differs turns onto output 2 if its destination column is higher, otherwise onto output 3. It turns only if no row-ring packet continues into that output. Link 0 is served before link 1. A packet that loses continues on its column ring as in R2/R3.
- R5: A packet whose row and column both match is presented on the eject port one cycle later when the eject slot is free (`ej_valid` low or `ej_ready` high). Ring links have priority in index order 0..3, ahead of a self-addressed packet at the FIFO head. Ring packets that are not taken continue as in R2/R3.
- R6: While `ej_valid` is high and `ej_ready` is low, `ej_valid` stays high and `ej_pkt` holds its value.
- R7: Ring traffic is never dropped or delayed by the stop. The FIFO head leaves only into an output slot that neither ring traffic nor a turn uses in that cycle. Otherwise it waits, blocking the packets behind it.
- R8: The inject FIFO holds FIFO_DEPTH packets in arrival order. `inj_ready` is low exactly when it is full.
- R9: The FIFO head is steered onto output 0 or 1 toward its destination row when the rows differ, onto output 2 or 3 toward its destination column when only the columns differ, and to the eject port when both match.
- R10: A ring input with no neighbour upstream (link 0 at row 0, link 1 at the highest row, link 2 at column 0, link 3 at the highest column) is ignored. An output pointing off the die is never valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_valid | input | 4 | Slot occupied on each incoming ring link |
| ring_in_pkt | input | 4 x PKT_W | Packet on each incoming ring link |
| ring_out_valid | output | 4 | Slot occupied on each outgoing ring link |
| ring_out_pkt | output | 4 x PKT_W | Packet on each outgoing ring link |
| inj_valid | input | 1 | Local source offers a packet |
| inj_ready | output | 1 | Inject FIFO has room |
| inj_pkt | input | PKT_W | Packet offered for injection |
| ej_valid | output | 1 | A packet for this stop is on the eject port |
| ej_ready | input | 1 | Local sink takes the eject packet |
| ej_pkt | output | PKT_W | Packet delivered to this stop |

## Verification
Assertions check on every cycle that outputs pointing off the die stay idle, that a stalled eject packet is held steady, that only packets addressed to this stop leave on the eject port, that no live ring packet is lost from one cycle to the next, that the FIFO grows on an unmatched accept, and that the row ring only carries packets whose row matches. The exact choice of output, the turn and eject priorities, the fold-back target, head-of-line waiting behind ring traffic and FIFO ordering can only be shown by the bench's scenarios. In those scenarios a reference model predicts every output slot cycle by cycle.

// File: rtl/mesh_ring_pkg.sv
package mesh_ring_pkg;

  localparam int NDIR = 4;

  // Link directions. Bit 0 selects the sense, bit 1 selects the ring.
  typedef enum logic [1:0] {
    DIR_ROW_UP   = 2'd0,  // toward higher rows
    DIR_ROW_DOWN = 2'd1,  // toward lower rows
    DIR_COL_UP   = 2'd2,  // toward higher columns
    DIR_COL_DOWN = 2'd3   // toward lower columns
  } dir_e;

  function automatic int coord_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mrs_link_route.sv
module mrs_link_route
  import mesh_ring_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int MY_ROW = 1,
  parameter int MY_COL = 0,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int DIR    = 0
)(
  input  logic             valid,
  input  logic [ROW_W-1:0] dst_row,
  input  logic [COL_W-1:0] dst_col,
  output logic             live,
  output logic             at_dest,
  output logic             turn_req,
  output logic [1:0]       turn_dir,
  output logic [1:0]       cont_dir
);

  localparam logic [ROW_W-1:0] ROW_ME = ROW_W'(MY_ROW);
  localparam logic [COL_W-1:0] COL_ME = COL_W'(MY_COL);
  localparam bit ON_COL_RING = (DIR == 0) || (DIR == 1);

  // Is there a neighbour feeding this link, and one beyond it downstream?
  localparam bit HAS_UPSTREAM =
      (DIR == 0) ? (MY_ROW > 0) :
      (DIR == 1) ? (MY_ROW < ROWS - 1) :
      (DIR == 2) ? (MY_COL > 0) : (MY_COL < COLS - 1);
  localparam bit AT_EDGE =
      (DIR == 0) ? (MY_ROW == ROWS - 1) :
      (DIR == 1) ? (MY_ROW == 0) :
      (DIR == 2) ? (MY_COL == COLS - 1) : (MY_COL == 0);

  logic row_hit, col_hit;

  always_comb begin
    row_hit  = (dst_row == ROW_ME);
    col_hit  = (dst_col == COL_ME);
    live     = valid && HAS_UPSTREAM;
    at_dest  = live && row_hit && col_hit;
    turn_req = live && ON_COL_RING && row_hit && !col_hit;
    turn_dir = (dst_col > COL_ME) ? DIR_COL_UP : DIR_COL_DOWN;
    cont_dir = AT_EDGE ? 2'(DIR ^ 1) : 2'(DIR);
  end

endmodule

// File: rtl/mrs_inject_fifo.sv
module mrs_inject_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic             head_valid,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_valid = (count != '0);
  assign head       = mem[rd_ptr];

endmodule

// File: rtl/mrs_link_reg.sv
module mrs_link_reg #(
  parameter int W = 12
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d_pkt,
  output logic         q_valid,
  output logic [W-1:0] q_pkt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pkt   <= '0;
    end else if (en) begin
      q_valid <= d_valid;
      q_pkt   <= d_pkt;
    end
  end

endmodule

// File: rtl/mesh_ring_stop.sv
module mesh_ring_stop
  import mesh_ring_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int MY_ROW     = 1,
  parameter int MY_COL     = 0,
  parameter int PAY_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int ROW_W = coord_width(ROWS),
  localparam int COL_W = coord_width(COLS),
  localparam int PKT_W = ROW_W + COL_W + PAY_W
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NDIR-1:0]            ring_in_valid,
  input  logic [NDIR-1:0][PKT_W-1:0] ring_in_pkt,
  output logic [NDIR-1:0]            ring_out_valid,
  output logic [NDIR-1:0][PKT_W-1:0] ring_out_pkt,
  input  logic                       inj_valid,
  output logic                       inj_ready,
  input  logic [PKT_W-1:0]           inj_pkt,
  output logic                       ej_valid,
  input  logic                       ej_ready,
  output logic [PKT_W-1:0]           ej_pkt
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ROW_W-1:0] ROW_ME = ROW_W'(MY_ROW);
  localparam logic [COL_W-1:0] COL_ME = COL_W'(MY_COL);

  // Per-link routing decisions
  logic [NDIR-1:0]       live, at_dest, turn_req;
  logic [NDIR-1:0][1:0]  turn_dir, cont_dir;

  for (genvar d = 0; d < NDIR; d++) begin : g_route
    mrs_link_route #(
      .ROWS(ROWS), .COLS(COLS), .MY_ROW(MY_ROW), .MY_COL(MY_COL),
      .ROW_W(ROW_W), .COL_W(COL_W), .DIR(d)
    ) u_route (
      .valid    (ring_in_valid[d]),
      .dst_row  (ring_in_pkt[d][PKT_W-1 -: ROW_W]),
      .dst_col  (ring_in_pkt[d][PAY_W +: COL_W]),
      .live     (live[d]),
      .at_dest  (at_dest[d]),
      .turn_req (turn_req[d]),
      .turn_dir (turn_dir[d]),
      .cont_dir (cont_dir[d])
    );
  end

  // Inject FIFO
  logic             fifo_push, inj_pop, head_valid;
  logic [PKT_W-1:0] head;
  logic [CNT_W-1:0] fifo_count;

  assign inj_ready = (fifo_count != CNT_W'(FIFO_DEPTH));
  assign fifo_push = inj_valid && inj_ready;

  mrs_inject_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (fifo_push),
    .push_data  (inj_pkt),
    .pop        (inj_pop),
    .head_valid (head_valid),
    .head       (head),
    .count      (fifo_count)
  );

  // Slot allocation: eject, row-ring traffic, column ring with turns, then injection
  logic                       ej_slot_free, ej_sel_valid, head_self;
  logic [PKT_W-1:0]           ej_sel_pkt;
  logic [NDIR-1:0]            ej_take, occ;
  logic [NDIR-1:0][PKT_W-1:0] nxt_pkt;
  logic [1:0]                 head_dir;
  logic [ROW_W-1:0]           head_row;
  logic [COL_W-1:0]           head_col;

  always_comb begin
    ej_slot_free = !ej_valid || ej_ready;
    ej_sel_valid = 1'b0;
    ej_sel_pkt   = '0;
    ej_take      = '0;
    occ          = '0;
    nxt_pkt      = '0;
    inj_pop      = 1'b0;

    head_row  = head[PKT_W-1 -: ROW_W];
    head_col  = head[PAY_W +: COL_W];
    head_self = head_valid && (head_row == ROW_ME) && (head_col == COL_ME);
    if (head_row != ROW_ME)
      head_dir = (head_row > ROW_ME) ? DIR_ROW_UP : DIR_ROW_DOWN;
    else
      head_dir = (head_col > COL_ME) ? DIR_COL_UP : DIR_COL_DOWN;

    // Eject: ring links in index order, then a self-addressed FIFO head
    for (int d = 0; d < NDIR; d++) begin
      if (ej_slot_free && !ej_sel_valid && at_dest[d]) begin
        ej_sel_valid = 1'b1;
        ej_sel_pkt   = ring_in_pkt[d];
        ej_take[d]   = 1'b1;
      end
    end
    if (ej_slot_free && !ej_sel_valid && head_self) begin
      ej_sel_valid = 1'b1;
      ej_sel_pkt   = head;
      inj_pop      = 1'b1;
    end

    // Row-ring traffic keeps its slot (continue or fold back)
    for (int d = 2; d < NDIR; d++) begin
      if (live[d] && !ej_take[d]) begin
        occ[cont_dir[d]]     = 1'b1;
        nxt_pkt[cont_dir[d]] = ring_in_pkt[d];
      end
    end

    // Column-ring traffic: turn into a free row slot, otherwise keep going
    for (int d = 0; d < 2; d++) begin
      if (live[d] && !ej_take[d]) begin
        if (turn_req[d] && !occ[turn_dir[d]]) begin
          occ[turn_dir[d]]     = 1'b1;
          nxt_pkt[turn_dir[d]] = ring_in_pkt[d];
        end else begin
          occ[cont_dir[d]]     = 1'b1;
          nxt_pkt[cont_dir[d]] = ring_in_pkt[d];
        end
      end
    end

    // Local injection waits for a gap
    if (head_valid && !head_self && !occ[head_dir]) begin
      occ[head_dir]     = 1'b1;
      nxt_pkt[head_dir] = head;
      inj_pop           = 1'b1;
    end
  end

  // Output registers
  for (genvar d = 0; d < NDIR; d++) begin : g_out
    mrs_link_reg #(.W(PKT_W)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (1'b1),
      .d_valid (occ[d]),
      .d_pkt   (nxt_pkt[d]),
      .q_valid (ring_out_valid[d]),
      .q_pkt   (ring_out_pkt[d])
    );
  end

  mrs_link_reg #(.W(PKT_W)) u_eject (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ej_slot_free),
    .d_valid (ej_sel_valid),
    .d_pkt   (ej_sel_pkt),
    .q_valid (ej_valid),
    .q_pkt   (ej_pkt)
  );

endmodule

// File: rtl/mesh_ring_stop_chk.sv
module mesh_ring_stop_chk
  import mesh_ring_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int MY_ROW     = 1,
  parameter int MY_COL     = 0,
  parameter int PAY_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int ROW_W = coord_width(ROWS),
  localparam int COL_W = coord_width(COLS),
  localparam int PKT_W = ROW_W + COL_W + PAY_W,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic [NDIR-1:0]            ring_in_valid,
  input logic [NDIR-1:0]            ring_out_valid,
  input logic [NDIR-1:0][PKT_W-1:0] ring_out_pkt,
  input logic                       inj_valid,
  input logic                       inj_ready,
  input logic                       ej_valid,
  input logic                       ej_ready,
  input logic [PKT_W-1:0]           ej_pkt,
  input logic                       inj_pop,
  input logic [CNT_W-1:0]           fifo_count
);

  localparam logic [ROW_W-1:0] ROW_ME = ROW_W'(MY_ROW);
  localparam logic [COL_W-1:0] COL_ME = COL_W'(MY_COL);
  localparam logic [NDIR-1:0] OFF_DIE = {MY_COL == 0, MY_COL == COLS - 1,
                                         MY_ROW == 0, MY_ROW == ROWS - 1};
  localparam logic [NDIR-1:0] NO_FEED = {MY_COL == COLS - 1, MY_COL == 0,
                                         MY_ROW == ROWS - 1, MY_ROW == 0};

  // R10: outputs that point off the die stay idle
  p_edge_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_out_valid & OFF_DIE) == '0);

  // R6: a stalled eject packet is held
  p_eject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid && !ej_ready |=> ej_valid && $stable(ej_pkt));

  // R5: only packets addressed here leave on the eject port
  p_eject_mine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (ej_pkt[PKT_W-1 -: ROW_W] == ROW_ME) && (ej_pkt[PAY_W +: COL_W] == COL_ME));

  // R7: live ring packets are not lost (at most one of them leaves by eject)
  p_ring_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(ring_out_valid) + 1) >= $countones($past(ring_in_valid & ~NO_FEED)));

  // R8: an accepted packet with no departure grows the FIFO by one
  p_fifo_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && inj_ready && !inj_pop |=> fifo_count == $past(fifo_count) + 1'b1);

  // R4: the row ring only carries packets whose row matches (given legal row-ring input)
  p_row_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid[2] |-> ring_out_pkt[2][PKT_W-1 -: ROW_W] == ROW_ME);

endmodule

bind mesh_ring_stop mesh_ring_stop_chk #(
  .ROWS(ROWS), .COLS(COLS), .MY_ROW(MY_ROW), .MY_COL(MY_COL),
  .PAY_W(PAY_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ring_in_valid  (ring_in_valid),
  .ring_out_valid (ring_out_valid),
  .ring_out_pkt   (ring_out_pkt),
  .inj_valid      (inj_valid),
  .inj_ready      (inj_ready),
  .ej_valid       (ej_valid),
  .ej_ready       (ej_ready),
  .ej_pkt         (ej_pkt),
  .inj_pop        (inj_pop),
  .fifo_count     (fifo_count)
);

// File: tb/test_mesh_ring_stop.sv
`timescale 1ns/1ps
module test_mesh_ring_stop;

  localparam int ROWS = 4, COLS = 4, MY_ROW = 1, MY_COL = 0, PAY_W = 8, DEPTH = 4;
  localparam int PKT_W = 2 + 2 + PAY_W;

  logic                  clk = 1'b0, rst_n = 1'b0;
  logic [3:0]            ring_in_valid = '0;
  logic [3:0][PKT_W-1:0] ring_in_pkt = '0;
  logic [3:0]            ring_out_valid;
  logic [3:0][PKT_W-1:0] ring_out_pkt;
  logic                  inj_valid = 1'b0, inj_ready, ej_valid, ej_ready = 1'b0;
  logic [PKT_W-1:0]      inj_pkt = '0, ej_pkt;

  always #2 clk = ~clk;

  mesh_ring_stop #(.ROWS(ROWS), .COLS(COLS), .MY_ROW(MY_ROW), .MY_COL(MY_COL),
                   .PAY_W(PAY_W), .FIFO_DEPTH(DEPTH)) i_mesh_ring_stop (
    .clk(clk), .rst_n(rst_n), .ring_in_valid(ring_in_valid), .ring_in_pkt(ring_in_pkt),
    .ring_out_valid(ring_out_valid), .ring_out_pkt(ring_out_pkt),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_pkt(inj_pkt),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_pkt(ej_pkt));

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  // Reference model state
  logic [PKT_W-1:0]      q[$];
  logic                  m_ej_valid = 1'b0;
  logic [PKT_W-1:0]      m_ej_pkt = '0;
  logic [3:0]            e_valid = '0;
  logic [3:0][PKT_W-1:0] e_pkt = '0;

  function automatic logic [PKT_W-1:0] mk(input int r, input int c, input int p);
    return {2'(r), 2'(c), 8'(p)};
  endfunction
  function automatic int row_of(input logic [PKT_W-1:0] p); return int'(p[11:10]); endfunction
  function automatic int col_of(input logic [PKT_W-1:0] p); return int'(p[9:8]); endfunction
  function automatic bit is_me(input logic [PKT_W-1:0] p);
    return row_of(p) == MY_ROW && col_of(p) == MY_COL;
  endfunction
  function automatic bit has_feed(input int d);
    case (d)
      0: return MY_ROW > 0;
      1: return MY_ROW < ROWS - 1;
      2: return MY_COL > 0;
      default: return MY_COL < COLS - 1;
    endcase
  endfunction
  function automatic int fwd(input int d);
    bit edge_here;
    case (d)
      0: edge_here = (MY_ROW == ROWS - 1);
      1: edge_here = (MY_ROW == 0);
      2: edge_here = (MY_COL == COLS - 1);
      default: edge_here = (MY_COL == 0);
    endcase
    return edge_here ? (d ^ 1) : d;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Predict next-cycle outputs from the inputs driven now (R2..R9)
  task automatic predict();
    bit slot, ej_sel, hv, pop;
    logic [PKT_W-1:0] ej_p, hd;
    bit [3:0] live, taken;
    int t, tgt;
    slot = !m_ej_valid || ej_ready;
    ej_sel = 0; ej_p = '0; taken = '0; pop = 0;
    e_valid = '0; e_pkt = '0;
    for (int d = 0; d < 4; d++) live[d] = ring_in_valid[d] && has_feed(d);
    for (int d = 0; d < 4; d++)
      if (slot && !ej_sel && live[d] && is_me(ring_in_pkt[d])) begin
        ej_sel = 1; ej_p = ring_in_pkt[d]; taken[d] = 1;
      end
    hv = q.size() > 0;
    hd = hv ? q[0] : '0;
    if (slot && !ej_sel && hv && is_me(hd)) begin ej_sel = 1; ej_p = hd; pop = 1; end
    for (int d = 2; d < 4; d++)
      if (live[d] && !taken[d]) begin e_valid[fwd(d)] = 1; e_pkt[fwd(d)] = ring_in_pkt[d]; end
    for (int d = 0; d < 2; d++)
      if (live[d] && !taken[d]) begin
        t = (col_of(ring_in_pkt[d]) > MY_COL) ? 2 : 3;
        if (row_of(ring_in_pkt[d]) == MY_ROW && col_of(ring_in_pkt[d]) != MY_COL && !e_valid[t]) begin
          e_valid[t] = 1; e_pkt[t] = ring_in_pkt[d];
        end else begin
          e_valid[fwd(d)] = 1; e_pkt[fwd(d)] = ring_in_pkt[d];
        end
      end
    if (hv && !is_me(hd)) begin
      if (row_of(hd) != MY_ROW) tgt = (row_of(hd) > MY_ROW) ? 0 : 1;
      else tgt = (col_of(hd) > MY_COL) ? 2 : 3;
      if (!e_valid[tgt]) begin e_valid[tgt] = 1; e_pkt[tgt] = hd; pop = 1; end
    end
    if (slot) begin m_ej_valid = ej_sel; if (ej_sel) m_ej_pkt = ej_p; end
    if (inj_valid && q.size() < DEPTH) begin
      if (pop) void'(q.pop_front());
      q.push_back(inj_pkt);
    end else if (pop) void'(q.pop_front());
  endtask

  // One clock: inputs are already driven (just after a falling edge)
  task automatic cycle(input string tag);
    check("R8", "inj_ready", inj_ready, q.size() < DEPTH);
    predict();
    @(negedge clk);
    for (int d = 0; d < 4; d++) begin
      check(tag, $sformatf("out_valid[%0d]", d), ring_out_valid[d], e_valid[d]);
      if (e_valid[d]) check(tag, $sformatf("out_pkt[%0d]", d), ring_out_pkt[d], e_pkt[d]);
    end
    check(tag, "ej_valid", ej_valid, m_ej_valid);
    if (m_ej_valid) check(tag, "ej_pkt", ej_pkt, m_ej_pkt);
  endtask

  task automatic idle();
    ring_in_valid = '0; ring_in_pkt = '0; inj_valid = 0; inj_pkt = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "ring_out_valid", ring_out_valid, 0);
    check("R1", "ej_valid", ej_valid, 0);
    check("R1", "inj_ready", inj_ready, 1);

    // R2: column ring pass-through, both senses
    ej_ready = 1;
    ring_in_valid = 4'b0011; ring_in_pkt[0] = mk(3, 2, 8'h11); ring_in_pkt[1] = mk(0, 3, 8'h12);
    cycle("R2");
    // R3: row ring at column 0 folds back onto the increasing-column output
    idle(); ring_in_valid[3] = 1; ring_in_pkt[3] = mk(1, 2, 8'h21);
    cycle("R3");
    // R4: turn east when the row slot is free
    idle(); ring_in_valid[0] = 1; ring_in_pkt[0] = mk(1, 3, 8'h31);
    cycle("R4");
    // R4: turn blocked by folding row traffic, packet continues on its column
    ring_in_valid[3] = 1; ring_in_pkt[3] = mk(1, 1, 8'h32);
    cycle("R4");
    // R4: both column links want to turn, link 0 wins
    idle(); ring_in_valid = 4'b0011; ring_in_pkt[0] = mk(1, 2, 8'h33); ring_in_pkt[1] = mk(1, 3, 8'h34);
    cycle("R4");
    // R5: ejection with link-order priority, loser keeps circulating
    idle(); ring_in_valid = 4'b1001; ring_in_pkt[0] = mk(1, 0, 8'h41); ring_in_pkt[3] = mk(1, 0, 8'h42);
    cycle("R5");
    // R6/R5: eject stalled -> held; self-addressed ring packet circulates
    ej_ready = 0; idle(); ring_in_valid[1] = 1; ring_in_pkt[1] = mk(1, 0, 8'h43);
    cycle("R5");
    idle();
    cycle("R6"); cycle("R6");
    ej_ready = 1; cycle("R6");
    // R9: injection directions and self-delivery
    idle(); inj_valid = 1; inj_pkt = mk(0, 2, 8'h51); cycle("R9");
    inj_pkt = mk(1, 3, 8'h52); cycle("R9");
    inj_pkt = mk(1, 0, 8'h53); cycle("R9");
    inj_pkt = mk(2, 1, 8'h54); cycle("R9");
    idle(); repeat (3) cycle("R9");
    // R7/R8: ring traffic blocks injection, FIFO fills, then drains in order
    ring_in_valid[0] = 1; ring_in_pkt[0] = mk(3, 0, 8'h61);
    inj_valid = 1;
    for (int i = 0; i < 6; i++) begin inj_pkt = mk(3, 1, 8'h70 + i); cycle("R8"); end
    check("R8", "inj_ready_full", inj_ready, 0);
    inj_valid = 0; cycle("R7");
    ring_in_valid = '0; repeat (6) cycle("R7");
    // R10: links without an upstream neighbour are ignored
    idle(); ring_in_valid[2] = 1; ring_in_pkt[2] = mk(1, 2, 8'h81);
    cycle("R10"); cycle("R10");
    check("R10", "ignored_in", ring_out_valid, 0);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ring_in_valid[0] = ($urandom % 3) == 0; ring_in_pkt[0] = mk($urandom % 4, $urandom % 4, $urandom);
      ring_in_valid[1] = ($urandom % 3) == 0; ring_in_pkt[1] = mk($urandom % 4, $urandom % 4, $urandom);
      ring_in_valid[2] = ($urandom % 2) == 0; ring_in_pkt[2] = mk($urandom % 4, $urandom % 4, $urandom);
      ring_in_valid[3] = ($urandom % 3) == 0; ring_in_pkt[3] = mk(MY_ROW, $urandom % 4, $urandom);
      inj_valid = ($urandom % 2) == 0; inj_pkt = mk($urandom % 4, $urandom % 4, $urandom);
      ej_ready = ($urandom % 4) != 0;
      cycle("R7");
    end
    idle(); ej_ready = 1;
    repeat (20) cycle("R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule